// File: doc/BRIEF.md
# Request/Wait Read Servant

This block answers single-word reads from a bus master over a two-wire control scheme. The master raises a request line with an address. The servant then either returns the word inside a fixed window of clock cycles, or asserts a wait line to stretch the transfer. A fast servant behaves like a plain strobe device. A slow one behaves like a handshake device. A single protocol covers both cases. The servant makes this choice again on every transfer.

The word comes from a small built-in read-only store whose contents are a fixed arithmetic pattern. Data is released only after the store's configurable latency has elapsed and while a backend-ready input is high. The backend-ready input lets the surrounding system model a source whose response time varies. When the master has taken the word, it lowers its request. The servant then clears its data output and rearms for the next transfer.

Top module: `reqwait_servant`

## Requirements
- R1: After reset, and whenever the servant is idle, `wait_o` is low and `rdata_o` is all zeros.
- R2: The request is sampled at edge E0, and the word is ready at edge Ek (k counted from 1). If k is WINDOW or less, `rdata_o` carries the word after Ek, and `wait_o` stays low for the whole transfer.
- R3: If no word is ready by edge E(WINDOW), `wait_o` goes high after that edge and stays high until the word is delivered.
- R4: In a stretched transfer, `wait_o` falls at the same edge that drives the word onto `rdata_o`. `rdata_o` stays zero while `wait_o` is high.
- R5: Once delivered, `rdata_o` holds its value for as long as `req_i` stays high.
- R6: At the first edge that samples `req_i` low after delivery, `rdata_o` returns to zero. The servant becomes idle at the edge after that.
- R7: A request held high after delivery never opens a second transfer: `wait_o` stays low and `rdata_o` stays unchanged, even when `addr_i` changes.
- R8: The word is taken from the address sampled at E0, and later changes of `addr_i` have no effect. The word at address a equals (a*PAT_MUL + PAT_ADD) modulo 2^DW.
- R9: A word is ready at Ek only when k is at least MEM_LAT and `backend_rdy_i` is high at that edge. When WINDOW is reached at the same edge as readiness, delivery wins over wait.

Top module ports are listed in order below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Read request from the master |
| addr_i | input | AW | Word address, sampled when a request is accepted |
| backend_rdy_i | input | 1 | High when the variable-latency source can deliver |
| wait_o | output | 1 | High while the servant is stretching the transfer |
| rdata_o | output | DW | Read word; zero when no word is being presented |

## Verification
The two events that can land on the same clock edge are the expiry of the access window and the word becoming ready. The bench provokes this by raising backend-ready exactly at edge E(WINDOW) and at every other offset around it. Each offset is swept across all sixteen addresses. For every edge, the bench computes arithmetically whether wait should be high and which word should appear. At the colliding edge, the word must be delivered with wait never having risen.

// File: rtl/reqwait_pkg.sv
package reqwait_pkg;

   typedef enum logic [2:0] {
      RW_IDLE       = 3'd0,
      RW_ACCESS     = 3'd1,
      RW_WAITING    = 3'd2,
      RW_DATA_VALID = 3'd3,
      RW_RECOVER    = 3'd4
   } rw_state_e;

   // Content of the built-in store: affine pattern of the word index.
   function automatic logic [31:0] rw_pattern(input int unsigned idx,
                                              input int unsigned mul,
                                              input int unsigned add);
      return 32'(idx * mul + add);
   endfunction

endpackage

// File: rtl/reqwait_store.sv
module reqwait_store #(
   parameter int AW      = 4,
   parameter int DW      = 8,
   parameter int PAT_MUL = 37,
   parameter int PAT_ADD = 5
) (
   input  logic [AW-1:0] rd_addr_i,
   output logic [DW-1:0] rd_word_o
);
   import reqwait_pkg::*;

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] words [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
      localparam logic [31:0] FULL = rw_pattern(gi, PAT_MUL, PAT_ADD);
      assign words[gi] = FULL[DW-1:0];
   end

   assign rd_word_o = words[rd_addr_i];

endmodule

// File: rtl/reqwait_age.sv
module reqwait_age #(
   parameter int WINDOW  = 2,
   parameter int MEM_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic run_i,
   output logic win_last_o,
   output logic lat_done_o
);
   localparam int AGE_MAX = (WINDOW > MEM_LAT) ? WINDOW : MEM_LAT;
   localparam int AGE_W   = $clog2(AGE_MAX + 1);

   logic [AGE_W-1:0] age_q;

   // age_q equals k while the transfer waits for edge Ek
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age_q <= '0;
      end else if (start_i) begin
         age_q <= AGE_W'(1);
      end else if (run_i && (age_q < AGE_W'(AGE_MAX))) begin
         age_q <= age_q + AGE_W'(1);
      end
   end

   assign win_last_o = (age_q == AGE_W'(WINDOW));

   if (MEM_LAT <= 1) begin : g_lat_none
      assign lat_done_o = 1'b1;
   end else begin : g_lat_count
      assign lat_done_o = (age_q >= AGE_W'(MEM_LAT));
   end

endmodule

// File: rtl/reqwait_servant.sv
module reqwait_servant #(
   parameter int AW      = 4,
   parameter int DW      = 8,
   parameter int WINDOW  = 2,
   parameter int MEM_LAT = 1,
   parameter int PAT_MUL = 37,
   parameter int PAT_ADD = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic [AW-1:0] addr_i,
   input  logic          backend_rdy_i,
   output logic          wait_o,
   output logic [DW-1:0] rdata_o
);
   import reqwait_pkg::*;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("reqwait_servant: AW out of range");
   end
   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("reqwait_servant: DW out of range");
   end
   if (WINDOW < 1) begin : g_bad_win
      $error("reqwait_servant: WINDOW must be at least one cycle");
   end
   if (MEM_LAT < 0) begin : g_bad_lat
      $error("reqwait_servant: MEM_LAT must not be negative");
   end

   rw_state_e     state_q;
   logic          wait_q;
   logic [DW-1:0] rdata_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] rd_word;
   logic          win_last;
   logic          lat_done;
   logic          start;
   logic          busy;
   logic          hit;

   assign start = (state_q == RW_IDLE) && req_i;
   assign busy  = (state_q == RW_ACCESS) || (state_q == RW_WAITING);
   assign hit   = lat_done && backend_rdy_i;

   reqwait_age #(
      .WINDOW (WINDOW),
      .MEM_LAT(MEM_LAT)
   ) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .run_i     (busy),
      .win_last_o(win_last),
      .lat_done_o(lat_done)
   );

   reqwait_store #(
      .AW     (AW),
      .DW     (DW),
      .PAT_MUL(PAT_MUL),
      .PAT_ADD(PAT_ADD)
   ) u_store (
      .rd_addr_i(addr_q),
      .rd_word_o(rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RW_IDLE;
         wait_q  <= 1'b0;
         rdata_q <= '0;
         addr_q  <= '0;
      end else begin
         unique case (state_q)
            RW_IDLE: begin
               if (req_i) begin
                  addr_q  <= addr_i;
                  state_q <= RW_ACCESS;
               end
            end
            RW_ACCESS: begin
               // readiness outranks window expiry on the same edge
               if (hit) begin
                  rdata_q <= rd_word;
                  state_q <= RW_DATA_VALID;
               end else if (win_last) begin
                  wait_q  <= 1'b1;
                  state_q <= RW_WAITING;
               end
            end
            RW_WAITING: begin
               if (hit) begin
                  rdata_q <= rd_word;
                  wait_q  <= 1'b0;
                  state_q <= RW_DATA_VALID;
               end
            end
            RW_DATA_VALID: begin
               if (!req_i) begin
                  rdata_q <= '0;
                  state_q <= RW_RECOVER;
               end
            end
            RW_RECOVER: begin
               state_q <= RW_IDLE;
            end
            default: begin
               state_q <= RW_IDLE;
               wait_q  <= 1'b0;
               rdata_q <= '0;
            end
         endcase
      end
   end

   assign wait_o  = wait_q;
   assign rdata_o = rdata_q;

endmodule

// File: rtl/reqwait_checker.sv
module reqwait_checker #(
   parameter int DW = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_i,
   input logic                   wait_o,
   input logic [DW-1:0]          rdata_o,
   input reqwait_pkg::rw_state_e state
);
   import reqwait_pkg::*;

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RW_IDLE) |-> (!wait_o && rdata_o == '0));

   a_r2_wait_only_when_stretching: assert property (@(posedge clk) disable iff (!rst_n)
      wait_o |-> (state == RW_WAITING));

   a_r3_wait_rise_from_access: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wait_o) |-> ($past(state) == RW_ACCESS && $past(req_i)));

   a_r4_wait_fall_delivers: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wait_o) |-> (state == RW_DATA_VALID));

   a_r4_no_data_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      wait_o |-> (rdata_o == '0));

   a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RW_DATA_VALID && $past(state) == RW_DATA_VALID) |-> $stable(rdata_o));

   a_r6_clear_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RW_RECOVER) |-> (rdata_o == '0 && $past(!req_i)));

   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == RW_DATA_VALID && $past(req_i)) |-> (state == RW_DATA_VALID && !wait_o));

endmodule

bind reqwait_servant reqwait_checker #(.DW(DW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .req_i  (req_i),
   .wait_o (wait_o),
   .rdata_o(rdata_o),
   .state  (state_q)
);

// File: tb/sim_reqwait_servant.sv
`timescale 1ns/100ps
module sim_reqwait_servant;

   localparam int AW    = 4;
   localparam int DW    = 8;
   localparam int WIN   = 3;
   localparam int LAT   = 2;
   localparam int MUL   = 37;
   localparam int ADD   = 5;
   localparam int MAXD  = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          backend_rdy_i = 1'b0;
   logic          wait_o;
   logic [DW-1:0] rdata_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   reqwait_servant #(
      .AW(AW), .DW(DW), .WINDOW(WIN), .MEM_LAT(LAT), .PAT_MUL(MUL), .PAT_ADD(ADD)
   ) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i),
      .addr_i       (addr_i),
      .backend_rdy_i(backend_rdy_i),
      .wait_o       (wait_o),
      .rdata_o      (rdata_o)
   );

   function automatic int expect_word(input int a);
      return (a * MUL + ADD) % (1 << DW);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_txn(input int a, input int d, input int hold);
      int k_ready;
      int w;
      k_ready = (d > LAT) ? d : LAT;
      if (k_ready < 1) k_ready = 1;
      req_i = 1'b1;
      addr_i = AW'(a);
      backend_rdy_i = 1'b0;
      tick();                       // E0 samples the request
      addr_i = AW'(a ^ 5);          // R8: later address changes must not matter
      for (int k = 1; k <= k_ready; k++) begin
         backend_rdy_i = (k >= d);
         tick();                    // Ek
         if (k < k_ready) begin
            w = (k >= WIN) ? 1 : 0;
            check(wait_o == w[0], (w != 0) ? "R3 wait asserted" : "R2 wait low in window",
                  int'(wait_o), w);
            check(rdata_o == '0, "R4 data zero before delivery", int'(rdata_o), 0);
         end else begin
            check(wait_o == 1'b0, (k_ready > WIN) ? "R4 wait falls at delivery" : "R2 fast no wait",
                  int'(wait_o), 0);
            check(int'(rdata_o) == expect_word(a), "R8 R9 delivered word",
                  int'(rdata_o), expect_word(a));
         end
      end
      for (int h = 0; h < hold; h++) begin
         addr_i = AW'(h * 3 + 1);
         backend_rdy_i = h[0];
         tick();
         check(int'(rdata_o) == expect_word(a), "R5 data held while req high",
               int'(rdata_o), expect_word(a));
         check(wait_o == 1'b0, "R7 no second transfer", int'(wait_o), 0);
      end
      req_i = 1'b0;
      backend_rdy_i = 1'b0;
      tick();
      check(rdata_o == '0, "R6 data cleared after release", int'(rdata_o), 0);
      tick();
      check(rdata_o == '0 && wait_o == 1'b0, "R1 idle quiet after recovery",
            int'(rdata_o), 0);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      rst_n = 1'b0;
      tick();
      tick();
      check(wait_o == 1'b0, "R1 reset wait low", int'(wait_o), 0);
      check(rdata_o == '0, "R1 reset data zero", int'(rdata_o), 0);
      rst_n = 1'b1;
      tick();
      check(wait_o == 1'b0 && rdata_o == '0, "R1 idle without request",
            int'(rdata_o), 0);
      // sweep readiness offset across the window edge, every address
      for (int d = 0; d <= MAXD; d++) begin
         for (int a = 0; a < (1 << AW); a++) begin
            run_txn(a, d, (a % 3) + 1);
         end
      end
      // long hold with request never dropped
      run_txn(9, WIN, 12);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule